// File: doc/BRIEF.md
# Data Access Watchpoint Checker

This block inspects every data memory access on its way to memory. Each access arrives as an address, a store flag and a valid strobe. The block relocates low addresses into a process-specific region. It flags a misaligned access as an alignment abort when that check is turned on. It also compares the relocated address with two data watchpoint registers and reports a hit together with a method-of-entry code. All three results leave the block one clock after the access, in the same cycle.

Software sets the checker up through a small write port. The port selects one of five configuration registers by a 3-bit code:

- the relocation base
- the system control word, which holds the alignment enable
- watchpoint address 0
- watchpoint address 1
- the watchpoint control word

The watchpoint control word holds two 2-bit access-type enables and a mask-mode bit. When the mask-mode bit is set, the second watchpoint register becomes an inverse address mask for the first.

Top module: `data_watch_checker`

## Requirements
- R1: After reset, `out_valid`, `out_addr`, `align_abort`, `wp_hit` and `wp_moe` are zero, and every configuration register is zero. Accesses therefore pass unrelocated, never abort and never hit.
- R2: Let the relocation base bits 31:25 be nonzero, and let the access address bits 31:25 all be zero. Then `out_addr` equals the access address ORed with the base bits 31:25.
- R3: In all other cases `out_addr` equals the access address. Relocation base bits 24:0 never affect the result.
- R4: `align_abort` pulses when system control bit 1 is set and address bits 1:0 are nonzero. Other bits of the system control word have no effect on the abort.
- R5: Each comparator has a 2-bit access-type enable, whose codes are listed below. Comparator 0 takes its enable from control bits 1:0, and comparator 1 from control bits 3:2.
  - 0: the comparator is off.
  - 1: the comparator matches stores only.
  - 2: the comparator matches loads and stores.
  - 3: the comparator matches loads only.
- R6: With control bit 8 clear, the two comparators work independently. Each matches when address bits 31:2 equal bits 31:2 of its own register, and address bits 1:0 are ignored.
- R7: With control bit 8 set, only comparator 0 can hit, and the bit 3:2 enables are ignored. Comparator 0 matches when (address AND NOT wp1) equals (wp0 AND NOT wp1).
- R8: On a hit, `wp_hit` is 1 and `wp_moe` is 2. This is the value of a field at bits 4:2, so the word value is 0x8. When there is no hit, `wp_moe` is 0.
- R9: The results are registered. An access taken on a rising edge shows `out_valid` and its results for exactly one cycle after that edge. Without an access, all pulse outputs are 0.
- R10: The watchpoint compare and the alignment check use the relocated address.
- R11: The write select codes are 0 for the relocation base, 1 for system control, 2 for wp0, 3 for wp1 and 4 for watchpoint control. Writes with codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration register select code |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access strobe |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | 32 | Access address |
| out_valid | output | 1 | Registered access result valid |
| out_addr | output | 32 | Relocated address |
| align_abort | output | 1 | Alignment abort pulse |
| wp_hit | output | 1 | Watchpoint hit pulse |
| wp_moe | output | 3 | Method-of-entry field, 2 on a data watchpoint hit |

## Verification
Relocation is tried in several ways:
- Addresses with clear upper bits, which separates the OR path from pass-through.
- Addresses with set upper bits.
- A base that has only its low bits set, which shows that bits 24:0 are dropped.

Each enable code is applied to both loads and stores, at the exact address, at an address that differs only in bits 1:0, and at the next word. This separates type filtering from the word compare. Mask mode is tried with an address that hits only in independent mode, and with an address that differs only in masked-out bits. This sets the masked compare apart from the per-register compare.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    // configuration register select codes
    typedef enum logic [2:0] {
        SEL_RELOC = 3'd0,
        SEL_SYSCTL = 3'd1,
        SEL_WP0 = 3'd2,
        SEL_WP1 = 3'd3,
        SEL_WCTL = 3'd4
    } cfg_sel_e;

    // access-type enable codes of one comparator
    typedef enum logic [1:0] {
        WEN_OFF = 2'd0,
        WEN_STORE = 2'd1,
        WEN_ANY = 2'd2,
        WEN_LOAD = 2'd3
    } wp_en_e;

    localparam int SYS_ALIGN_BIT = 1;
    localparam int WCTL_MASK_BIT = 8;
    localparam int WCTL_EN_W = 2;
    localparam logic [2:0] MOE_DATA_WP = 3'd2;

    // decoded control state
    typedef struct packed {
        logic align_en;
        logic mask_mode;
        wp_en_e en1;
        wp_en_e en0;
    } ctl_t;

    function automatic logic type_match(wp_en_e en, logic store);
        case (en)
            WEN_STORE: return store;
            WEN_ANY: return 1'b1;
            WEN_LOAD: return !store;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wpc_cfg_regs.sv
module wpc_cfg_regs
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic clk,
    input logic rst,
    input logic we,
    input logic [2:0] sel,
    input logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] reloc_q,
    output logic [ADDR_W-1:0] wp0_q,
    output logic [ADDR_W-1:0] wp1_q,
    output ctl_t ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reloc_q <= '0;
            wp0_q <= '0;
            wp1_q <= '0;
            ctl_q <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_RELOC: reloc_q <= wdata;
                SEL_SYSCTL: ctl_q.align_en <= wdata[SYS_ALIGN_BIT];
                SEL_WP0: wp0_q <= wdata;
                SEL_WP1: wp1_q <= wdata;
                SEL_WCTL: begin
                    ctl_q.mask_mode <= wdata[WCTL_MASK_BIT];
                    ctl_q.en0 <= wp_en_e'(wdata[WCTL_EN_W-1:0]);
                    ctl_q.en1 <= wp_en_e'(wdata[2*WCTL_EN_W-1:WCTL_EN_W]);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wpc_relocate.sv
module wpc_relocate #(
    parameter int ADDR_W = 32,
    parameter int PID_LSB = 25
) (
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] reloc_base,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int HI_W = ADDR_W - PID_LSB;

    logic [HI_W-1:0] base_hi;
    logic use_base;

    always_comb begin
        base_hi = reloc_base[ADDR_W-1:PID_LSB];
        use_base = (base_hi != '0) && (addr_in[ADDR_W-1:PID_LSB] == '0);
        addr_out = addr_in;
        if (use_base)
            addr_out[ADDR_W-1:PID_LSB] = base_hi;
    end

endmodule

// File: rtl/wpc_compare.sv
module wpc_compare
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_WP = 2
) (
    input logic [ADDR_W-1:0] addr,
    input logic store,
    input logic [ADDR_W-1:0] wp0,
    input logic [ADDR_W-1:0] wp1,
    input ctl_t ctl,
    output logic [NUM_WP-1:0] hit_vec
);

    logic [NUM_WP-1:0][ADDR_W-1:0] wp_regs;
    wp_en_e [NUM_WP-1:0] wp_ens;
    logic [NUM_WP-1:0] ind_hit;
    logic mask_hit;

    assign wp_regs[0] = wp0;
    assign wp_regs[1] = wp1;
    assign wp_ens[0] = ctl.en0;
    assign wp_ens[1] = ctl.en1;

    genvar g;
    generate
        for (g = 0; g < NUM_WP; g++) begin : g_cmp
            assign ind_hit[g] = type_match(wp_ens[g], store)
                && (addr[ADDR_W-1:2] == wp_regs[g][ADDR_W-1:2]);
        end
    endgenerate

    assign mask_hit = type_match(ctl.en0, store)
        && ((addr & ~wp1) == (wp0 & ~wp1));

    always_comb begin
        if (ctl.mask_mode) begin
            hit_vec = '0;
            hit_vec[0] = mask_hit;
        end else begin
            hit_vec = ind_hit;
        end
    end

endmodule

// File: rtl/data_watch_checker.sv
module data_watch_checker
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PID_LSB = 25,
    parameter int NUM_WP = 2
) (
    input logic clk,
    input logic rst,
    input logic cfg_we,
    input logic [2:0] cfg_sel,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic acc_valid,
    input logic acc_store,
    input logic [ADDR_W-1:0] acc_addr,
    output logic out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic align_abort,
    output logic wp_hit,
    output logic [2:0] wp_moe
);

    logic [ADDR_W-1:0] reloc_q, wp0_q, wp1_q, reloc_addr;
    ctl_t ctl_q;
    logic [NUM_WP-1:0] hit_vec;
    logic any_hit, misalign;

    wpc_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .reloc_q(reloc_q), .wp0_q(wp0_q), .wp1_q(wp1_q), .ctl_q(ctl_q)
    );

    wpc_relocate #(.ADDR_W(ADDR_W), .PID_LSB(PID_LSB)) u_reloc (
        .addr_in(acc_addr), .reloc_base(reloc_q), .addr_out(reloc_addr)
    );

    wpc_compare #(.ADDR_W(ADDR_W), .NUM_WP(NUM_WP)) u_cmp (
        .addr(reloc_addr), .store(acc_store), .wp0(wp0_q), .wp1(wp1_q),
        .ctl(ctl_q), .hit_vec(hit_vec)
    );

    assign any_hit = |hit_vec;
    assign misalign = ctl_q.align_en && (reloc_addr[1:0] != 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr <= '0;
            align_abort <= 1'b0;
            wp_hit <= 1'b0;
            wp_moe <= '0;
        end else begin
            out_valid <= acc_valid;
            if (acc_valid)
                out_addr <= reloc_addr;
            align_abort <= acc_valid && misalign;
            wp_hit <= acc_valid && any_hit;
            wp_moe <= (acc_valid && any_hit) ? MOE_DATA_WP : 3'd0;
        end
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(acc_valid));
    a_r9_pulse_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (wp_hit || align_abort) |-> out_valid);
    a_r8_hit_code: assert property (@(posedge clk) disable iff (rst)
        wp_hit |-> (wp_moe == MOE_DATA_WP));
    a_r8_idle_code: assert property (@(posedge clk) disable iff (rst)
        !wp_hit |-> (wp_moe == 3'd0));
    a_r7_single_cmp: assert property (@(posedge clk) disable iff (rst)
        ctl_q.mask_mode |-> !hit_vec[1]);
    a_r4_abort_low_bits: assert property (@(posedge clk) disable iff (rst)
        align_abort |-> (out_addr[1:0] != 2'b00));
    a_r3_low_bits_kept: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_addr[PID_LSB-1:0] == $past(acc_addr[PID_LSB-1:0])));

endmodule

// File: tb/data_watch_checker_tb.sv
module data_watch_checker_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic acc_valid = 1'b0;
    logic acc_store = 1'b0;
    logic [31:0] acc_addr = '0;
    logic out_valid, align_abort, wp_hit;
    logic [31:0] out_addr;
    logic [2:0] wp_moe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    data_watch_checker u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_store(acc_store),
        .acc_addr(acc_addr), .out_valid(out_valid), .out_addr(out_addr),
        .align_abort(align_abort), .wp_hit(wp_hit), .wp_moe(wp_moe)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input bit store, input logic [31:0] addr,
                          input logic [31:0] exp_addr, input bit exp_abort,
                          input bit exp_hit, input string tag);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_store = store;
        acc_addr = addr;
        @(negedge clk);
        acc_valid = 1'b0;
        check(out_valid == 1'b1, {tag, " valid"}, 32'(out_valid), 32'd1);
        check(out_addr == exp_addr, {tag, " addr"}, out_addr, exp_addr);
        check(align_abort == exp_abort, {tag, " abort"}, 32'(align_abort), 32'(exp_abort));
        check(wp_hit == exp_hit, {tag, " hit"}, 32'(wp_hit), 32'(exp_hit));
        check(wp_moe == (exp_hit ? 3'd2 : 3'd0), {tag, " R8 moe"}, 32'(wp_moe),
              exp_hit ? 32'd2 : 32'd0);
    endtask

    task automatic clear_cfg();
        for (int s = 0; s < 5; s++) cfg_write(3'(s), 32'h0);
    endtask

    task automatic t_reset();
        check(out_valid == 0 && out_addr == 0 && align_abort == 0 && wp_hit == 0
              && wp_moe == 0, "R1 reset outputs", {out_addr[28:0], out_valid,
              align_abort, wp_hit}, 32'h0);
        access(1'b0, 32'h0000_0043, 32'h0000_0043, 1'b0, 1'b0, "R1 unconfigured");
        access(1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, "R1 zero addr");
    endtask

    task automatic t_reloc();
        clear_cfg();
        cfg_write(3'd0, 32'h5A00_0000);
        access(1'b0, 32'h0001_2340, 32'h5A01_2340, 1'b0, 1'b0, "R2 low addr reloc");
        access(1'b1, 32'h01FF_FFFC, 32'h5BFF_FFFC, 1'b0, 1'b0, "R2 top low addr");
        access(1'b0, 32'h8000_0010, 32'h8000_0010, 1'b0, 1'b0, "R3 high addr passes");
        access(1'b0, 32'h0200_0000, 32'h0200_0000, 1'b0, 1'b0, "R3 bit25 set passes");
        cfg_write(3'd0, 32'h01FF_FFFF);
        access(1'b0, 32'h0000_0100, 32'h0000_0100, 1'b0, 1'b0, "R3 base low bits dropped");
    endtask

    task automatic t_align();
        clear_cfg();
        access(1'b0, 32'h0000_0003, 32'h0000_0003, 1'b0, 1'b0, "R4 disabled");
        cfg_write(3'd1, 32'h0000_0002);
        access(1'b0, 32'h0000_1002, 32'h0000_1002, 1'b1, 1'b0, "R4 misaligned");
        access(1'b1, 32'h0000_1001, 32'h0000_1001, 1'b1, 1'b0, "R4 misaligned store");
        access(1'b0, 32'h0000_1000, 32'h0000_1000, 1'b0, 1'b0, "R4 aligned");
        cfg_write(3'd1, 32'hFFFF_FFFD);
        access(1'b0, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, "R4 other bits no effect");
    endtask

    task automatic t_enables();
        clear_cfg();
        cfg_write(3'd2, 32'h0000_4000);
        for (int code = 0; code < 4; code++) begin
            cfg_write(3'd4, 32'(code));
            for (int st = 0; st < 2; st++) begin
                automatic bit exp = (code == 2) || (st == 1 ? code == 1 : code == 3);
                access(st[0], 32'h0000_4000, 32'h0000_4000, 1'b0, exp, "R5 enable code");
                access(st[0], 32'h0000_4003, 32'h0000_4003, 1'b0, exp, "R6 low bits ignored");
                access(st[0], 32'h0000_4004, 32'h0000_4004, 1'b0, 1'b0, "R6 next word miss");
            end
        end
    endtask

    task automatic t_comp1();
        clear_cfg();
        cfg_write(3'd2, 32'h0000_4000);
        cfg_write(3'd3, 32'h0000_8000);
        cfg_write(3'd4, 32'h0000_0008);
        access(1'b0, 32'h0000_8002, 32'h0000_8002, 1'b0, 1'b1, "R6 comp1 hit");
        access(1'b1, 32'h0000_4000, 32'h0000_4000, 1'b0, 1'b0, "R5 comp0 off");
        cfg_write(3'd4, 32'h0000_0004);
        access(1'b0, 32'h0000_8000, 32'h0000_8000, 1'b0, 1'b0, "R5 comp1 store-only load");
        access(1'b1, 32'h0000_8000, 32'h0000_8000, 1'b0, 1'b1, "R5 comp1 store-only store");
    endtask

    task automatic t_mask();
        clear_cfg();
        cfg_write(3'd2, 32'h1234_5600);
        cfg_write(3'd3, 32'h0000_00FF);
        cfg_write(3'd4, 32'h0000_000A);
        access(1'b0, 32'h0000_00FC, 32'h0000_00FC, 1'b0, 1'b1, "R6 indep comp1 hit");
        cfg_write(3'd4, 32'h0000_010A);
        access(1'b0, 32'h0000_00FC, 32'h0000_00FC, 1'b0, 1'b0, "R7 comp1 inactive");
        access(1'b0, 32'h1234_56AB, 32'h1234_56AB, 1'b0, 1'b1, "R7 masked hit");
        access(1'b1, 32'h1234_5700, 32'h1234_5700, 1'b0, 1'b0, "R7 unmasked diff miss");
        cfg_write(3'd4, 32'h0000_0103);
        access(1'b1, 32'h1234_5611, 32'h1234_5611, 1'b0, 1'b0, "R7 load-only store miss");
        access(1'b0, 32'h1234_5611, 32'h1234_5611, 1'b0, 1'b1, "R7 load-only load hit");
    endtask

    task automatic t_reloc_compare();
        clear_cfg();
        cfg_write(3'd2, 32'h0400_1000);
        cfg_write(3'd4, 32'h0000_0002);
        cfg_write(3'd1, 32'h0000_0002);
        access(1'b0, 32'h0000_1000, 32'h0000_1000, 1'b0, 1'b0, "R10 no reloc miss");
        cfg_write(3'd0, 32'h0400_0000);
        access(1'b0, 32'h0000_1000, 32'h0400_1000, 1'b0, 1'b1, "R10 reloc hit");
        access(1'b1, 32'h0000_1002, 32'h0400_1002, 1'b1, 1'b1, "R10 reloc abort and hit");
    endtask

    task automatic t_pulse();
        @(negedge clk);
        check(out_valid == 0 && wp_hit == 0 && align_abort == 0 && wp_moe == 0,
              "R9 idle after hit", {wp_moe, out_valid, wp_hit, align_abort}, 32'h0);
        @(negedge clk);
        check(out_valid == 0 && wp_hit == 0, "R9 stays idle",
              {out_valid, wp_hit}, 32'h0);
    endtask

    task automatic t_bad_sel();
        clear_cfg();
        for (int s = 5; s < 8; s++) cfg_write(3'(s), 32'hFFFF_FFFF);
        access(1'b0, 32'h0000_0003, 32'h0000_0003, 1'b0, 1'b0, "R11 unused select ignored");
        access(1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, "R11 unused select no hit");
        cfg_write(3'd1, 32'h0000_0002);
        access(1'b0, 32'h0000_0003, 32'h0000_0003, 1'b1, 1'b0, "R11 select 1 is sysctl");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reloc();
        t_align();
        t_enables();
        t_comp1();
        t_mask();
        t_reloc_compare();
        t_pulse();
        t_bad_sel();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule